// File: doc/BRIEF.md
# Byte/Word Load-Store Unit

This block is the memory access stage of a small 16-bit RISC core. Each cycle it may take one decoded memory instruction. The opcode selects one of two address sources. The first is a base register plus a 5-bit signed displacement. The second is the sum of two registers. The opcode also selects the direction (load or store) and the width (16-bit word or 8-bit byte). The block forms a 16-bit byte address and drives a synchronous memory port with one enable per byte lane. For loads, it hands the aligned result back to the register file together with the destination index.

Memory is little-endian: the byte at the even address sits in bits 7:0 of a word. Word accesses must be aligned. A misaligned word access is dropped before it reaches memory and is reported by a one-cycle flag. Load data returns one cycle after the request, marked by a valid pulse.

Top module: `lsu_core`

## Requirements
- R1: An access is issued only when `req_i` is high and `op_i[4:3]` is `2'b10`. In that opcode, bit 2 selects the address source (0: `base_i` plus displacement, 1: `reg_a_i` plus `reg_b_i`), bit 1 selects byte width and bit 0 selects a store. Any other opcode leaves `mem_req_o`, `mem_we_o` and `mem_be_o` at zero and produces no load result.
- R2: The 5-bit `disp_i` is sign-extended before it is added, so `5'b11111` means -1.
- R3: Address sums wrap modulo 2^16.
- R4: A word store drives `mem_be_o = 2'b11` and `mem_wdata_o = store_data_i`. The low byte goes to the even address, so a word read afterwards returns `{byte[a+1], byte[a]}`.
- R5: A byte store enables only the lane selected by address bit 0 (`2'b01` for even, `2'b10` for odd). It places the low byte of `store_data_i` in both halves of `mem_wdata_o`, and leaves the other byte of memory unchanged.
- R6: A load raises `load_valid_o` for one cycle, exactly one cycle after the request. For a word load, `load_data_o` is the little-endian 16-bit word.
- R7: A byte load returns the addressed byte zero-extended to 16 bits.
- R8: A word access with address bit 0 set asserts no `mem_req_o` and changes no memory. It raises `misalign_o` for one cycle, one cycle after the request, and produces no `load_valid_o`.
- R9: `load_dest_o` carries the `dest_i` of the load it belongs to, including for back-to-back loads.
- R10: While `rst_ni` is low, `load_valid_o` and `misalign_o` are low, and no memory request is driven while `req_i` is low.
- R11: Byte accesses at odd addresses never raise `misalign_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Instruction valid this cycle |
| op_i | input | 5 | Major opcode |
| dest_i | input | 3 | Destination register index for loads |
| base_i | input | 16 | Base register value (displacement mode) |
| disp_i | input | 5 | Signed displacement |
| reg_a_i | input | 16 | First register (register-sum mode) |
| reg_b_i | input | 16 | Second register (register-sum mode) |
| store_data_i | input | 16 | Store source register value |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Byte address |
| mem_be_o | output | 2 | Byte-lane enables |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after the request |
| load_valid_o | output | 1 | Load result valid |
| load_dest_o | output | 3 | Destination index of the result |
| load_data_o | output | 16 | Load result |
| misalign_o | output | 1 | Misaligned word access dropped |

## Verification
The assertions check several properties on every cycle. An idle port drives no enables and no write. A word request that reaches memory is always even. A byte store enables exactly one lane. Every issued load is followed by a valid pulse, and a valid pulse never coincides with a misalign flag. Only the scoreboard scenarios can show that the data is right. That covers sign-extended displacement, address wrap, little-endian lane placement, zero-extension of byte loads, and memory left unchanged by a dropped store and by neighbouring byte writes. It also covers destination tags on back-to-back loads.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef struct packed {
    logic valid;
    logic reg_mode;
    logic is_byte;
    logic store;
  } acc_dec_t;

  function automatic acc_dec_t decode_op(input logic [4:0] op, input logic req);
    acc_dec_t d;
    d.valid    = req && (op[4:3] == 2'b10);
    d.reg_mode = op[2];
    d.is_byte  = op[1];
    d.store    = op[0];
    return d;
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 5
) (
  input  logic              reg_mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] reg_a_i,
  input  logic [ADDR_W-1:0] reg_b_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  // sums truncate to ADDR_W: wraparound is intended
  assign addr_o   = reg_mode_i ? (reg_a_i + reg_b_i) : (base_i + disp_ext);
endmodule

// File: rtl/lsu_store_align.sv
module lsu_store_align #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              is_byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] sdata_i,
  output logic [DATA_W/8-1:0] be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              misalign_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] lane;

  assign lane       = addr_i[LANE_W-1:0];
  assign misalign_o = !is_byte_i && (|lane);

  always_comb begin
    be_o = '0;
    if (is_byte_i) begin
      for (int i = 0; i < LANES; i++)
        if (lane == LANE_W'(i)) be_o[i] = 1'b1;
    end else begin
      be_o = '1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata_o[g*8 +: 8] = is_byte_i ? sdata_i[7:0] : sdata_i[g*8 +: 8];
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_load_i,
  input  logic              drop_i,
  input  logic              is_byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  dest_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  dest_o,
  output logic [DATA_W-1:0] data_o,
  output logic              misalign_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic              byte_q;
  logic [LANE_W-1:0] lane_q;
  logic [7:0]        byte_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      misalign_o <= 1'b0;
      byte_q     <= 1'b0;
      lane_q     <= '0;
      dest_o     <= '0;
    end else begin
      valid_o    <= issue_load_i;
      misalign_o <= drop_i;
      if (issue_load_i) begin
        byte_q <= is_byte_i;
        lane_q <= addr_i[LANE_W-1:0];
        dest_o <= dest_i;
      end
    end
  end

  always_comb begin
    byte_sel = '0;
    for (int i = 0; i < LANES; i++)
      if (lane_q == LANE_W'(i)) byte_sel = rdata_i[i*8 +: 8];
  end

  assign data_o = byte_q ? {{(DATA_W-8){1'b0}}, byte_sel} : rdata_i;

  assert_valid_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_load_i |=> valid_o);
  assert_flag_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && misalign_o));
endmodule

// File: rtl/lsu_core.sv
module lsu_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int DISP_W = 5,
  parameter int IDX_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [4:0]          op_i,
  input  logic [IDX_W-1:0]    dest_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [DISP_W-1:0]   disp_i,
  input  logic [ADDR_W-1:0]   reg_a_i,
  input  logic [ADDR_W-1:0]   reg_b_i,
  input  logic [DATA_W-1:0]   store_data_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                load_valid_o,
  output logic [IDX_W-1:0]    load_dest_o,
  output logic [DATA_W-1:0]   load_data_o,
  output logic                misalign_o
);
  import lsu_pkg::*;

  localparam int LANES = DATA_W / 8;

  acc_dec_t          dec;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] wdata;
  logic              mis;
  logic              go;

  assign dec = decode_op(op_i, req_i);

  lsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) i_agen (
    .reg_mode_i (dec.reg_mode),
    .base_i     (base_i),
    .disp_i     (disp_i),
    .reg_a_i    (reg_a_i),
    .reg_b_i    (reg_b_i),
    .addr_o     (addr)
  );

  lsu_store_align #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
    .is_byte_i  (dec.is_byte),
    .addr_i     (addr),
    .sdata_i    (store_data_i),
    .be_o       (be),
    .wdata_o    (wdata),
    .misalign_o (mis)
  );

  assign go          = dec.valid && !mis;
  assign mem_req_o   = go;
  assign mem_we_o    = go && dec.store;
  assign mem_addr_o  = addr;
  assign mem_be_o    = go ? be : '0;
  assign mem_wdata_o = (go && dec.store) ? wdata : '0;

  lsu_load_align #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_load (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_load_i (go && !dec.store),
    .drop_i       (dec.valid && mis),
    .is_byte_i    (dec.is_byte),
    .addr_i       (addr),
    .dest_i       (dest_i),
    .rdata_i      (mem_rdata_i),
    .valid_o      (load_valid_o),
    .dest_o       (load_dest_o),
    .data_o       (load_data_o),
    .misalign_o   (misalign_o)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |-> (mem_be_o == '0 && !mem_we_o));
  assert_word_even_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !dec.is_byte) |-> !mem_addr_o[0]);
  assert_byte_one_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && dec.is_byte) |-> ($countones(mem_be_o) == 1));
  assert_byte_no_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.valid && dec.is_byte) |=> !misalign_o);
endmodule

// File: tb/test_lsu_core.sv
module test_lsu_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [2:0]  dest_i = '0;
  logic [15:0] base_i = '0, reg_a_i = '0, reg_b_i = '0, store_data_i = '0;
  logic [4:0]  disp_i = '0;
  logic        mem_req_o, mem_we_o, load_valid_o, misalign_o;
  logic [15:0] mem_addr_o, mem_wdata_o, load_data_o;
  logic [15:0] mem_rdata_i = '0;
  logic [1:0]  mem_be_o;
  logic [2:0]  load_dest_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {bit mis; bit [2:0] dest; bit [15:0] data; string tag;} exp_t;
  exp_t exp_q[$];
  bit [7:0] mem_b[int];
  bit [7:0] ref_b[int];

  always #2.5 clk_i = ~clk_i;

  lsu_core i_lsu_core (.*);

  function automatic bit [7:0] rd_mem(int a);
    return mem_b.exists(a) ? mem_b[a] : 8'h00;
  endfunction
  function automatic bit [7:0] rd_ref(int a);
    return ref_b.exists(a) ? ref_b[a] : 8'h00;
  endfunction

  // memory model: synchronous, one-cycle read
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      int wa;
      wa = int'({mem_addr_o[15:1], 1'b0});
      if (mem_we_o) begin
        if (mem_be_o[0]) mem_b[wa]   = mem_wdata_o[7:0];
        if (mem_be_o[1]) mem_b[wa+1] = mem_wdata_o[15:8];
      end else begin
        mem_rdata_i <= {rd_mem(wa+1), rd_mem(wa)};
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && (load_valid_o || misalign_o)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected result", {load_valid_o, misalign_o}, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.mis) begin
          chk(misalign_o && !load_valid_o, "R8", {"misalign flag ", e.tag},
              {load_valid_o, misalign_o}, 1);
        end else begin
          chk(load_valid_o && !misalign_o, "R6", {"valid ", e.tag},
              {load_valid_o, misalign_o}, 2);
          chk(load_data_o == e.data, e.tag, "load data", load_data_o, e.data);
          chk(load_dest_o == e.dest, "R9", {"dest ", e.tag}, load_dest_o, e.dest);
        end
      end
    end
  end

  task automatic access(input bit [4:0] op, input bit [15:0] base, input bit [4:0] disp,
                        input bit [15:0] ra, input bit [15:0] rb, input bit [15:0] sd,
                        input bit [2:0] dest, input string tag);
    bit [15:0] a;
    bit        bytew, st, mis, memop;
    @(negedge clk_i);
    req_i = 1'b1; op_i = op; base_i = base; disp_i = disp; reg_a_i = ra; reg_b_i = rb;
    store_data_i = sd; dest_i = dest;
    memop = (op[4:3] == 2'b10);
    a     = op[2] ? 16'(ra + rb) : 16'(base + {{11{disp[4]}}, disp});
    bytew = op[1]; st = op[0];
    mis   = memop && !bytew && a[0];
    #1;
    if (!memop) begin
      chk(!mem_req_o && !mem_we_o && mem_be_o == 2'b00, "R1", {"non-memory op ", tag},
          {mem_req_o, mem_we_o, mem_be_o}, 0);
    end else if (mis) begin
      chk(!mem_req_o && !mem_we_o, "R8", {"dropped request ", tag}, {mem_req_o, mem_we_o}, 0);
      exp_q.push_back('{1'b1, 3'd0, 16'h0, tag});
    end else begin
      chk(mem_req_o && mem_we_o == st, "R1", {"request ", tag}, {mem_req_o, mem_we_o}, {1'b1, st});
      chk(mem_addr_o == a, "R2", {"address ", tag}, mem_addr_o, a);
      if (st && !bytew) begin
        chk(mem_be_o == 2'b11 && mem_wdata_o == sd, "R4", {"word store bus ", tag},
            {mem_be_o, mem_wdata_o}, {2'b11, sd});
        ref_b[int'(a)] = sd[7:0]; ref_b[int'(a)+1] = sd[15:8];
      end else if (st) begin
        chk(mem_be_o == (a[0] ? 2'b10 : 2'b01) && mem_wdata_o == {sd[7:0], sd[7:0]}, "R5",
            {"byte store bus ", tag}, {mem_be_o, mem_wdata_o},
            {(a[0] ? 2'b10 : 2'b01), sd[7:0], sd[7:0]});
        ref_b[int'(a)] = sd[7:0];
      end else if (bytew) begin
        exp_q.push_back('{1'b0, dest, {8'h00, rd_ref(int'(a))}, "R7"});
      end else begin
        exp_q.push_back('{1'b0, dest, {rd_ref(int'(a)+1), rd_ref(int'(a))}, "R6"});
      end
    end
  endtask

  task automatic idle(int n);
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!load_valid_o && !misalign_o && !mem_req_o, "R10", "reset state",
        {load_valid_o, misalign_o, mem_req_o}, 0);
    rst_ni = 1'b1;
    idle(1);
    // R4: word store via displacement; R6: word load via register sum
    access(5'b10001, 16'h1000, 5'd4, 16'h0, 16'h0, 16'hBEEF, 3'd0, "w st");
    access(5'b10100, 16'h0, 5'd0, 16'h1000, 16'h0004, 16'h0, 3'd1, "w ld");
    // R2: displacement -1, R7: zero-extended byte 0xBE
    access(5'b10010, 16'h1006, 5'b11111, 16'h0, 16'h0, 16'h0, 3'd3, "b ld neg disp");
    // R5: byte store even lane then word readback (little-endian R4)
    access(5'b10011, 16'h1004, 5'd0, 16'h0, 16'h0, 16'h12A5, 3'd0, "b st even");
    access(5'b10000, 16'h1000, 5'd4, 16'h0, 16'h0, 16'h0, 3'd2, "w ld after b st");
    // R5 odd lane, register-sum mode, R11 odd byte no flag
    access(5'b10111, 16'h0, 5'd0, 16'h1000, 16'h0007, 16'h3377, 3'd0, "b st odd");
    access(5'b10100, 16'h0, 5'd0, 16'h1000, 16'h0006, 16'h0, 3'd4, "w ld odd lane");
    access(5'b10110, 16'h0, 5'd0, 16'h1000, 16'h0007, 16'h0, 3'd5, "b ld odd R11");
    // R3: wraparound in both modes
    access(5'b10011, 16'hFFFE, 5'd3, 16'h0, 16'h0, 16'h005C, 3'd0, "b st wrap");
    access(5'b10110, 16'h0, 5'd0, 16'hFFFF, 16'h0002, 16'h0, 3'd6, "b ld wrap R3");
    // R8: misaligned word store and load
    access(5'b10001, 16'h1003, 5'd2, 16'h0, 16'h0, 16'hDEAD, 3'd0, "w st misaligned");
    access(5'b10000, 16'h1000, 5'd4, 16'h0, 16'h0, 16'h0, 3'd7, "w ld after drop R8");
    access(5'b10100, 16'h0, 5'd0, 16'h1000, 16'h0001, 16'h0, 3'd2, "w ld misaligned");
    // R1: non-memory opcode
    access(5'b00110, 16'h1000, 5'd4, 16'h1000, 16'h4, 16'hFFFF, 3'd1, "alu op");
    idle(3);
    // R9: back-to-back loads with distinct destinations
    access(5'b10000, 16'h1004, 5'd0, 16'h0, 16'h0, 16'h0, 3'd1, "b2b a");
    access(5'b10010, 16'h1004, 5'd3, 16'h0, 16'h0, 16'h0, 3'd6, "b2b b");
    access(5'b10110, 16'h0, 5'd0, 16'h0000, 16'h0001, 16'h0, 3'd3, "b2b c");
    idle(4);
    chk(exp_q.size() == 0, "R6", "outstanding expectations", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule